// File: doc/BRIEF.md
# Processor Privilege Check Unit

This block holds the processor's privilege flag S, which is 0 in user state and 1 in supervisor state. Each cycle it inspects at most one decoded operation strobe: a register write with its destination index, an interrupt-lock flag update, a call, a trap, an exception, or a return. Register writes into the high global bank and raises of the interrupt-lock flag L are privileged. The unit grants them in supervisor state. In user state it refuses them, suppresses them, and requests a privilege-error trap.

For every call, trap, exception and privilege-error entry, the unit supplies the return PC to save with the current S packed into bit 0. For a return, it passes the PC out with bit 0 cleared. It also passes out the saved status word with bit 18 overwritten by bit 0 of the saved PC, so the new privilege is known in the same cycle the return PC is issued. S then takes that value at the next clock edge, ready for the first fetch.

A two-state machine holds S. It has the states PRIV_SUPER and PRIV_USER, and its transitions are:
- PRIV_SUPER to PRIV_USER on a granted return whose PC bit 0 is 0.
- PRIV_SUPER to PRIV_SUPER on any other operation.
- PRIV_USER to PRIV_SUPER on a trap, an exception or a privilege error.
- PRIV_USER to PRIV_USER otherwise.

A trap request carries a 6-bit entry vector index (0 to 63). A memory-cycle qualifier lets the unit drive S onto a privilege pin for external memory management.

Top module: `priv_check_unit`

## Requirements
- R1: After reset, S is 1, L is 1, no trap is requested, and `mem_priv` is 1 while `mem_req` is high.
- R2: In user state, a register write with destination index 16 to 31 is refused: `trap_req` is 1 and `trap_vec` is the privilege-error index 61 in the same cycle.
- R3: In user state, an L update that would change L from 0 to 1 is a privilege error and leaves L at 0. Clearing L in user state, and any L update in supervisor state, is granted and takes effect at the next edge.
- R4: Call, trap and exception assert `save_valid` with `save_pc` equal to `cur_pc` with bit 0 replaced by the current S.
- R5: For a return, `ret_pc_out` is `ret_pc_in` with bit 0 cleared, and `ret_sr_out` is `ret_sr_in` with bit 18 replaced by `ret_pc_in[0]`. A granted return sets S to `ret_pc_in[0]` from the next cycle.
- R6: A return in user state with `ret_pc_in[0]` = 1 is refused (`ret_grant` 0) and requests a privilege-error trap. It saves `cur_pc` with bit 0 forced to 1, and S is 1 from the next cycle.
- R7: S goes from 0 to 1 only through a trap, an exception or a privilege error. A trap or exception requests a trap with `trap_vec` equal to its own index, and sets S to 1 from the next cycle.
- R8: Every privilege error asserts `trap_req` and `save_valid` with `trap_vec` = 61, and sets S to 1 from the next cycle.
- R9: `mem_priv` equals S while `mem_req` is 1 and is 0 otherwise. In the first cycle after a granted return, it already shows the restored S.
- R10: A refused register write or L update drives its grant low. At most one operation strobe is high in any cycle.
- R11: Register writes with index 0 to 15, and all register writes in supervisor state, are granted with no trap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_regwr | input | 1 | Register write strobe |
| regwr_idx | input | 5 | Destination register index |
| op_lock | input | 1 | Interrupt-lock flag update strobe |
| lock_val | input | 1 | New value for L |
| op_call | input | 1 | Call strobe |
| op_trap | input | 1 | Trap instruction strobe |
| trap_idx | input | 6 | Entry index of the trap instruction |
| op_exc | input | 1 | Exception strobe |
| exc_idx | input | 6 | Entry index of the exception |
| op_ret | input | 1 | Return strobe |
| ret_pc_in | input | 32 | Saved return PC (bit 0 holds the saved S) |
| ret_sr_in | input | 32 | Saved status word |
| cur_pc | input | 32 | PC to be saved on entry |
| mem_req | input | 1 | A memory or I/O cycle is active |
| s_flag | output | 1 | Current privilege flag S |
| lock_flag | output | 1 | Current interrupt-lock flag L |
| mem_priv | output | 1 | Privilege signal for memory management |
| regwr_grant | output | 1 | Register write may proceed |
| lock_grant | output | 1 | L update may proceed |
| ret_grant | output | 1 | Return may proceed |
| ret_pc_out | output | 32 | Return target PC with bit 0 cleared |
| ret_sr_out | output | 32 | Restored status word |
| save_valid | output | 1 | `save_pc` must be stored |
| save_pc | output | 32 | Return PC to save, S in bit 0 |
| trap_req | output | 1 | Trap entry request |
| trap_vec | output | 6 | Entry vector index of the trap |

## Verification
The assertions rely on the decoder raising no more than one operation strobe per cycle. Without that, an error and an entry in the same cycle would have no single defined vector. The random stimulus therefore picks one operation kind, or none, per cycle, and then fills in random indices, lock values, PCs and status words. Returns are drawn with bit 0 of the saved PC set about half the time, so the bench exercises both user-to-supervisor refusals and drops to user state.

// File: rtl/priv_pkg.sv
package priv_pkg;

    typedef enum logic {
        PRIV_USER  = 1'b0,
        PRIV_SUPER = 1'b1
    } priv_state_e;

    typedef struct packed {
        logic regwr;
        logic lock;
        logic call;
        logic trap;
        logic exc;
        logic ret;
    } op_strobe_t;

endpackage

// File: rtl/priv_rule_check.sv
module priv_rule_check
    import priv_pkg::*;
#(
    parameter int IDX_W     = 5,
    parameter int HIGH_BASE = 16
) (
    input  priv_state_e      state,
    input  logic             lock_q,
    input  logic             do_regwr,
    input  logic             do_lock,
    input  logic             do_ret,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             lock_val,
    input  logic             ret_bit,
    output logic             err,
    output logic             err_on_ret,
    output logic             regwr_ok,
    output logic             lock_ok,
    output logic             ret_ok
);
    localparam logic [IDX_W-1:0] HIGH_FIRST = IDX_W'(HIGH_BASE);

    logic in_user;
    logic hit_high;
    logic bad_reg;
    logic bad_lock;
    logic bad_ret;

    always_comb begin
        in_user    = (state == PRIV_USER);
        hit_high   = (wr_idx >= HIGH_FIRST);
        bad_reg    = in_user && do_regwr && hit_high;
        bad_lock   = in_user && do_lock && lock_val && !lock_q;
        bad_ret    = in_user && do_ret && ret_bit;
        err        = bad_reg || bad_lock || bad_ret;
        err_on_ret = bad_ret;
        regwr_ok   = do_regwr && !bad_reg;
        lock_ok    = do_lock && !bad_lock;
        ret_ok     = do_ret && !bad_ret;
    end

endmodule

// File: rtl/priv_state_fsm.sv
module priv_state_fsm
    import priv_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        go_super,
    input  logic        ret_apply,
    input  logic        ret_bit,
    input  logic        lock_we,
    input  logic        lock_d,
    output priv_state_e state,
    output logic        lock_q
);
    priv_state_e state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= PRIV_SUPER;
            lock_q <= 1'b1;
        end else begin
            state <= state_d;
            if (lock_we) begin
                lock_q <= lock_d;
            end
        end
    end

    always_comb begin
        state_d = state;
        unique case (state)
            PRIV_USER: begin
                if (go_super) begin
                    state_d = PRIV_SUPER;
                end
            end
            PRIV_SUPER: begin
                if (!go_super && ret_apply && !ret_bit) begin
                    state_d = PRIV_USER;
                end
            end
            default: state_d = PRIV_SUPER;
        endcase
    end

    // R7: leaving user state needs an entry request in the previous cycle
    assert_no_silent_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PRIV_USER) |=> (state == PRIV_USER) || $past(go_super));

endmodule

// File: rtl/priv_frame_pack.sv
module priv_frame_pack #(
    parameter int                PC_W     = 32,
    parameter int                SR_W     = 32,
    parameter int                S_BIT    = 18,
    parameter int                VEC_W    = 6,
    parameter logic [VEC_W-1:0]  PRIV_VEC = 6'd61
) (
    input  logic             s_cur,
    input  logic             err,
    input  logic             err_on_ret,
    input  logic             do_call,
    input  logic             do_trap,
    input  logic             do_exc,
    input  logic [VEC_W-1:0] trap_idx,
    input  logic [VEC_W-1:0] exc_idx,
    input  logic [PC_W-1:0]  cur_pc,
    input  logic [PC_W-1:0]  ret_pc,
    input  logic [SR_W-1:0]  ret_sr,
    output logic             save_valid,
    output logic [PC_W-1:0]  save_pc,
    output logic [PC_W-1:0]  ret_pc_out,
    output logic [SR_W-1:0]  ret_sr_out,
    output logic             trap_req,
    output logic [VEC_W-1:0] trap_vec
);
    localparam logic [PC_W-1:0] LOW_CLR = ~PC_W'(1);

    logic save_bit;

    always_comb begin
        save_bit   = err_on_ret ? 1'b1 : s_cur;
        save_valid = do_call || do_trap || do_exc || err;
        save_pc    = (cur_pc & LOW_CLR) | PC_W'(save_bit);
        ret_pc_out = ret_pc & LOW_CLR;
        ret_sr_out = ret_sr;
        ret_sr_out[S_BIT] = ret_pc[0];
        trap_req   = do_trap || do_exc || err;
        if (err) begin
            trap_vec = PRIV_VEC;
        end else if (do_trap) begin
            trap_vec = trap_idx;
        end else if (do_exc) begin
            trap_vec = exc_idx;
        end else begin
            trap_vec = '0;
        end
    end

endmodule

// File: rtl/priv_check_unit.sv
module priv_check_unit
    import priv_pkg::*;
#(
    parameter int               PC_W      = 32,
    parameter int               SR_W      = 32,
    parameter int               S_BIT     = 18,
    parameter int               IDX_W     = 5,
    parameter int               HIGH_BASE = 16,
    parameter int               VEC_W     = 6,
    parameter logic [VEC_W-1:0] PRIV_VEC  = 6'd61
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             op_regwr,
    input  logic [IDX_W-1:0] regwr_idx,
    input  logic             op_lock,
    input  logic             lock_val,
    input  logic             op_call,
    input  logic             op_trap,
    input  logic [VEC_W-1:0] trap_idx,
    input  logic             op_exc,
    input  logic [VEC_W-1:0] exc_idx,
    input  logic             op_ret,
    input  logic [PC_W-1:0]  ret_pc_in,
    input  logic [SR_W-1:0]  ret_sr_in,
    input  logic [PC_W-1:0]  cur_pc,
    input  logic             mem_req,
    output logic             s_flag,
    output logic             lock_flag,
    output logic             mem_priv,
    output logic             regwr_grant,
    output logic             lock_grant,
    output logic             ret_grant,
    output logic [PC_W-1:0]  ret_pc_out,
    output logic [SR_W-1:0]  ret_sr_out,
    output logic             save_valid,
    output logic [PC_W-1:0]  save_pc,
    output logic             trap_req,
    output logic [VEC_W-1:0] trap_vec
);
    localparam logic [IDX_W-1:0] HIGH_FIRST = IDX_W'(HIGH_BASE);

    op_strobe_t  op;
    priv_state_e state;
    logic        err;
    logic        err_on_ret;
    logic        lock_q;
    logic        go_super;

    assign op = '{regwr: op_regwr, lock: op_lock, call: op_call,
                  trap: op_trap, exc: op_exc, ret: op_ret};

    priv_rule_check #(.IDX_W(IDX_W), .HIGH_BASE(HIGH_BASE)) u_rules (
        .state      (state),
        .lock_q     (lock_q),
        .do_regwr   (op.regwr),
        .do_lock    (op.lock),
        .do_ret     (op.ret),
        .wr_idx     (regwr_idx),
        .lock_val   (lock_val),
        .ret_bit    (ret_pc_in[0]),
        .err        (err),
        .err_on_ret (err_on_ret),
        .regwr_ok   (regwr_grant),
        .lock_ok    (lock_grant),
        .ret_ok     (ret_grant)
    );

    assign go_super = op.trap || op.exc || err;

    priv_state_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .go_super  (go_super),
        .ret_apply (ret_grant),
        .ret_bit   (ret_pc_in[0]),
        .lock_we   (lock_grant),
        .lock_d    (lock_val),
        .state     (state),
        .lock_q    (lock_q)
    );

    priv_frame_pack #(
        .PC_W(PC_W), .SR_W(SR_W), .S_BIT(S_BIT), .VEC_W(VEC_W), .PRIV_VEC(PRIV_VEC)
    ) u_frame (
        .s_cur      (s_flag),
        .err        (err),
        .err_on_ret (err_on_ret),
        .do_call    (op.call),
        .do_trap    (op.trap),
        .do_exc     (op.exc),
        .trap_idx   (trap_idx),
        .exc_idx    (exc_idx),
        .cur_pc     (cur_pc),
        .ret_pc     (ret_pc_in),
        .ret_sr     (ret_sr_in),
        .save_valid (save_valid),
        .save_pc    (save_pc),
        .ret_pc_out (ret_pc_out),
        .ret_sr_out (ret_sr_out),
        .trap_req   (trap_req),
        .trap_vec   (trap_vec)
    );

    always_comb begin
        s_flag    = (state == PRIV_SUPER);
        lock_flag = lock_q;
        mem_priv  = mem_req && s_flag;
    end

    // R10: input contract, one operation per cycle
    assert_one_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({op_regwr, op_lock, op_call, op_trap, op_exc, op_ret}));

    assert_high_write_trap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!s_flag && op_regwr && regwr_idx >= HIGH_FIRST)
        |-> (trap_req && !regwr_grant && trap_vec == PRIV_VEC));

    assert_lock_raise_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!s_flag && op_lock && lock_val && !lock_flag) |=> !lock_flag);

    assert_entry_saves_s_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (op_call || op_trap || op_exc) |-> (save_valid && save_pc[0] == s_flag));

    assert_ret_restores_s_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ret_grant |=> (s_flag == $past(ret_pc_in[0])));

    assert_ret_sr_bit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        op_ret |-> (ret_sr_out[S_BIT] == ret_pc_in[0]));

    assert_ret_escalate_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!s_flag && op_ret && ret_pc_in[0]) |-> (trap_req && !ret_grant && save_pc[0]));

    assert_error_enters_super_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_req && trap_vec == PRIV_VEC && !op_trap && !op_exc) |=> s_flag);

    assert_mem_priv_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_req |-> !mem_priv);

    assert_mem_priv_after_ret_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ret_grant |=> (!mem_req || mem_priv == $past(ret_pc_in[0])));

endmodule

// File: tb/tb_priv_check_unit.sv
module tb_priv_check_unit;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        op_regwr, op_lock, lock_val, op_call, op_trap, op_exc, op_ret, mem_req;
    logic [4:0]  regwr_idx;
    logic [5:0]  trap_idx, exc_idx;
    logic [31:0] ret_pc_in, ret_sr_in, cur_pc;
    logic        s_flag, lock_flag, mem_priv, regwr_grant, lock_grant, ret_grant;
    logic        save_valid, trap_req;
    logic [31:0] ret_pc_out, ret_sr_out, save_pc;
    logic [5:0]  trap_vec;

    int checks = 0;
    int errors = 0;
    logic ms, ml;   // model of S and L

    always #4 clk = ~clk;   // 125 MHz

    priv_check_unit dut (
        .clk(clk), .rst_n(rst_n), .op_regwr(op_regwr), .regwr_idx(regwr_idx),
        .op_lock(op_lock), .lock_val(lock_val), .op_call(op_call), .op_trap(op_trap),
        .trap_idx(trap_idx), .op_exc(op_exc), .exc_idx(exc_idx), .op_ret(op_ret),
        .ret_pc_in(ret_pc_in), .ret_sr_in(ret_sr_in), .cur_pc(cur_pc), .mem_req(mem_req),
        .s_flag(s_flag), .lock_flag(lock_flag), .mem_priv(mem_priv),
        .regwr_grant(regwr_grant), .lock_grant(lock_grant), .ret_grant(ret_grant),
        .ret_pc_out(ret_pc_out), .ret_sr_out(ret_sr_out), .save_valid(save_valid),
        .save_pc(save_pc), .trap_req(trap_req), .trap_vec(trap_vec)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic model_err(input int k, input logic [4:0] idx, input logic lv,
                                       input logic rbit);
        if (ms) return 1'b0;
        return (k == 1 && idx >= 5'd16) || (k == 2 && lv && !ml) || (k == 6 && rbit);
    endfunction

    function automatic logic [31:0] exp_sr(input logic [31:0] rsr, input logic rbit);
        logic [31:0] v = rsr;
        v[18] = rbit;
        return v;
    endfunction

    // kind: 0 none, 1 regwr, 2 lock, 3 call, 4 trap, 5 exception, 6 return
    task automatic step(input int k, input logic [4:0] idx, input logic lv,
                        input logic [5:0] vec, input logic [31:0] rpc,
                        input logic [31:0] rsr, input logic [31:0] cpc, input logic mreq);
        logic e, etrap, esave;
        @(negedge clk);
        op_regwr = (k == 1); op_lock = (k == 2); op_call = (k == 3);
        op_trap  = (k == 4); op_exc  = (k == 5); op_ret  = (k == 6);
        regwr_idx = idx; lock_val = lv; trap_idx = vec; exc_idx = ~vec;
        ret_pc_in = rpc; ret_sr_in = rsr; cur_pc = cpc; mem_req = mreq;
        #1;
        e     = model_err(k, idx, lv, rpc[0]);
        etrap = e || k == 4 || k == 5;
        esave = e || k == 3 || k == 4 || k == 5;
        chk("R7 s_flag", {31'd0, s_flag}, {31'd0, ms});
        chk("R3 lock_flag", {31'd0, lock_flag}, {31'd0, ml});
        chk(k == 1 ? "R2 trap_req" : k == 2 ? "R3 trap_req" : k == 6 ? "R6 trap_req" : "R8 trap_req",
            {31'd0, trap_req}, {31'd0, etrap});
        if (etrap)
            chk(e ? "R8 trap_vec" : "R7 trap_vec", {26'd0, trap_vec},
                {26'd0, e ? 6'd61 : (k == 4 ? vec : ~vec)});
        chk(e ? "R10 regwr_grant" : "R11 regwr_grant", {31'd0, regwr_grant},
            {31'd0, k == 1 && !e});
        chk("R10 lock_grant", {31'd0, lock_grant}, {31'd0, k == 2 && !e});
        chk("R6 ret_grant", {31'd0, ret_grant}, {31'd0, k == 6 && !e});
        chk("R4 save_valid", {31'd0, save_valid}, {31'd0, esave});
        if (esave)
            chk(k == 6 ? "R6 save_pc" : "R4 save_pc", save_pc,
                {cpc[31:1], (e && k == 6) ? 1'b1 : ms});
        if (k == 6) begin
            chk("R5 ret_pc_out", ret_pc_out, {rpc[31:1], 1'b0});
            chk("R5 ret_sr_out", ret_sr_out, exp_sr(rsr, rpc[0]));
        end
        chk("R9 mem_priv", {31'd0, mem_priv}, {31'd0, mreq && ms});
        if (etrap) ms = 1'b1;
        else if (k == 6) ms = rpc[0];
        if (k == 2 && !e) ml = lv;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_0a17));
        rst_n = 1'b0;
        {op_regwr, op_lock, lock_val, op_call, op_trap, op_exc, op_ret} = '0;
        regwr_idx = '0; trap_idx = '0; exc_idx = '0;
        ret_pc_in = '0; ret_sr_in = '0; cur_pc = '0; mem_req = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 s_flag", {31'd0, s_flag}, 32'd1);
        chk("R1 lock_flag", {31'd0, lock_flag}, 32'd1);
        chk("R1 trap_req", {31'd0, trap_req}, 32'd0);
        chk("R1 mem_priv", {31'd0, mem_priv}, 32'd1);
        rst_n = 1'b1;
        ms = 1'b1; ml = 1'b1;

        // directed corners
        step(2, 0, 1'b1, 0, 0, 0, 0, 1'b0);                              // supervisor keeps L
        step(6, 0, 0, 0, 32'h0000_1000, 32'hFFFF_FFFF, 0, 1'b1);         // drop to user
        step(0, 0, 0, 0, 0, 0, 0, 1'b1);                                 // R9 first cycle after
        step(1, 5'd16, 0, 0, 0, 0, 32'h0000_2003, 1'b0);                 // boundary high reg
        step(6, 0, 0, 0, 32'h0000_4000, 32'h0004_0000, 0, 1'b1);         // back to user, SR18 cleared
        step(1, 5'd15, 0, 0, 0, 0, 0, 1'b0);                             // top low reg granted
        step(1, 5'd31, 0, 0, 0, 0, 32'h0000_3001, 1'b1);
        step(6, 0, 0, 0, 32'h0000_4000, 0, 0, 1'b0);
        step(2, 0, 1'b0, 0, 0, 0, 0, 1'b0);                              // user clears L
        step(2, 0, 1'b1, 0, 0, 0, 32'h0000_5000, 1'b0);                  // user raises L: error
        step(6, 0, 0, 0, 32'h0000_6000, 0, 0, 1'b0);
        step(6, 0, 0, 0, 32'h0000_7001, 32'h1234_5678, 32'h0000_8000, 1'b1); // escalation
        step(2, 0, 1'b1, 0, 0, 0, 0, 1'b0);                              // supervisor raises L
        step(6, 0, 0, 0, 32'h0000_9000, 0, 0, 1'b0);
        step(3, 0, 0, 0, 0, 0, 32'h0000_A002, 1'b1);                     // call in user
        step(4, 0, 0, 6'd63, 0, 0, 32'h0000_B000, 1'b1);                 // trap top index
        step(6, 0, 0, 0, 32'h0000_C000, 0, 0, 1'b0);
        step(5, 0, 0, 6'd0, 0, 0, 32'h0000_D000, 1'b1);                  // exception
        step(1, 5'd20, 0, 0, 0, 0, 0, 1'b0);                             // supervisor high write

        // constrained random
        for (int i = 0; i < 600; i++) begin
            step(int'($urandom_range(0, 6)), 5'($urandom), 1'($urandom), 6'($urandom),
                 $urandom, $urandom, $urandom, 1'($urandom));
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule